// File: doc/BRIEF.md
# Instruction-Count Fetch Thread Selector

This block decides, every clock, which hardware thread of a simultaneously multithreaded front end is granted the fetch slot. It keeps one occupancy counter per thread that tracks how many of that thread's instructions are currently between fetch and retirement. A thread with few instructions in the machine is moving quickly and is not clogging shared queues, so it is preferred. This steers fetch bandwidth toward productive threads and keeps any one thread from starving the others.

Each counter grows by the number of instructions the fetch unit reports as taken for that thread. It shrinks by the per-thread count of instructions that retired or were squashed in the same cycle. Both changes may land together. A per-thread spin flag pushes a thread that is only polling to the back of the line. An enable mask lets a higher-level controller shrink the set of competing threads when they interfere too much. Among threads with equal standing, a rotating pointer decides, and it moves past the thread that last fetched.

The grant is combinational from the registered counters, the pointer and the current mask and spin flags. The fetch unit reports back the thread and the amount it actually fetched.

Top module: `icount_fetch_sel`

## Requirements
- R1: While reset is asserted and after it, every occupancy counter reads 0 and the rotating pointer is 0, so with all threads enabled thread 0 is granted.
- R2: On a clock edge with fetch_valid high, the counter of thread fetch_tid rises by fetch_cnt. Other counters receive no fetch increment.
- R3: On a clock edge, each thread's counter falls by its own field of drain_cnt (field i at bits i*DCW upward). When an increment lands on the same edge, the counter moves by the net amount.
- R4: A counter never exceeds MAX_INFLIGHT. A net result above it is stored as MAX_INFLIGHT.
- R5: A counter never wraps below zero. A net result below zero is stored as 0.
- R6: Among enabled threads whose spin flag is low, the one with the smallest counter is granted.
- R7: A thread whose spin flag is high is granted only when no enabled thread has its spin flag low. Among such threads the smallest counter wins.
- R8: A thread whose thread_en bit is 0 is never granted. With no enabled thread, sel_valid is 0 and sel_thread is 0.
- R9: Ties are resolved by scanning from the pointer upward with wrap-around. After an edge with fetch_valid high, the pointer becomes fetch_tid+1 modulo N_THR. Otherwise it holds.
- R10: The grant follows thread_en and spin_wait in the same cycle they change, without a register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| thread_en | input | N_THR | Mask of threads allowed to compete |
| spin_wait | input | N_THR | Per-thread busy-waiting flag |
| fetch_valid | input | 1 | Fetch unit took instructions this cycle |
| fetch_tid | input | TID_W | Thread those instructions belong to |
| fetch_cnt | input | FCW | Number of instructions taken |
| drain_cnt | input | N_THR*DCW | Per-thread count of retired plus squashed instructions |
| sel_valid | output | 1 | A thread is granted |
| sel_thread | output | TID_W | Granted thread |
| occupancy | output | N_THR*CNT_W | Per-thread in-flight counters, thread i at bits i*CNT_W upward |

## Verification
The bench first drives long fetch runs with no drain, which pins counters at the ceiling. A design that wrapped there would suddenly favour the heaviest thread. It then drains far more than is present, where a design without a floor would wrap to a huge count and lock that thread out. Equal-count states are forced right after reset and after zero-size fetches, so a pointer that failed to advance, or advanced from the grant instead of the reported thread, shows up as the wrong winner. Mixed spin and enable masks, including the all-disabled and all-spinning cases, catch a selector that ranks a spinning thread by count alone or grants a masked thread.

// File: rtl/icfs_pkg.sv
package icfs_pkg;

  // Position reached after stepping k places from base on a ring of n slots.
  function automatic int ring_step(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction

endpackage

// File: rtl/icfs_inflight_ctr.sv
module icfs_inflight_ctr #(
  parameter int MAX_INFLIGHT = 20,
  parameter int CNT_W        = 5,
  parameter int FCW          = 3,
  parameter int DCW          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [FCW-1:0]   inc_amt,
  input  logic [DCW-1:0]   dec_amt,
  output logic [CNT_W-1:0] count
);

  localparam int SUM_W = CNT_W + FCW + 1;

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] dec_w;
  logic [SUM_W-1:0] net_w;
  logic [CNT_W-1:0] count_d;
  logic             count_ce;

  always_comb begin
    sum_q = SUM_W'(count) + (inc_en ? SUM_W'(inc_amt) : '0);
    dec_w = SUM_W'(dec_amt);
    net_w = '0;
    if (sum_q > dec_w) begin
      net_w = sum_q - dec_w;
    end
    if (net_w > SUM_W'(MAX_INFLIGHT)) begin
      count_d = CNT_W'(MAX_INFLIGHT);
    end else begin
      count_d = net_w[CNT_W-1:0];
    end
    count_ce = (inc_en && (inc_amt != '0)) || (dec_amt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_ce) begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/icfs_rr_ptr.sv
module icfs_rr_ptr #(
  parameter int N_THR = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [TID_W-1:0] last_tid,
  output logic [TID_W-1:0] ptr
);

  logic [TID_W-1:0] ptr_d;

  always_comb begin
    if (int'(last_tid) >= N_THR - 1) begin
      ptr_d = '0;
    end else begin
      ptr_d = last_tid + TID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/icfs_pick.sv
module icfs_pick #(
  parameter int N_THR = 4,
  parameter int TID_W = 2,
  parameter int CNT_W = 5
) (
  input  logic [N_THR*CNT_W-1:0] cnt_flat,
  input  logic [N_THR-1:0]       elig,
  input  logic [N_THR-1:0]       spin,
  input  logic [TID_W-1:0]       ptr,
  output logic                   pick_valid,
  output logic [TID_W-1:0]       pick_tid
);

  import icfs_pkg::*;

  logic [CNT_W-1:0] cnt_arr [N_THR];
  logic [N_THR-1:0] calm;
  logic [N_THR-1:0] tier;
  logic             found;
  logic [CNT_W-1:0] best_cnt;
  logic [TID_W-1:0] best_tid;

  for (genvar g = 0; g < N_THR; g++) begin : g_unpack
    assign cnt_arr[g] = cnt_flat[g*CNT_W +: CNT_W];
  end

  always_comb begin
    calm     = elig & ~spin;
    tier     = (|calm) ? calm : elig;
    found    = 1'b0;
    best_cnt = '0;
    best_tid = '0;
    for (int k = 0; k < N_THR; k++) begin
      int idx;
      idx = ring_step(int'(ptr), k, N_THR);
      if (tier[idx] && (!found || (cnt_arr[idx] < best_cnt))) begin
        found    = 1'b1;
        best_cnt = cnt_arr[idx];
        best_tid = TID_W'(idx);
      end
    end
  end

  assign pick_valid = found;
  assign pick_tid   = best_tid;

endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel #(
  parameter int N_THR        = 4,
  parameter int MAX_INFLIGHT = 20,
  parameter int FETCH_MAX    = 4,
  parameter int DRAIN_MAX    = 4,
  parameter int TID_W        = (N_THR > 1) ? $clog2(N_THR) : 1,
  parameter int CNT_W        = $clog2(MAX_INFLIGHT + 1),
  parameter int FCW          = $clog2(FETCH_MAX + 1),
  parameter int DCW          = $clog2(DRAIN_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_THR-1:0]       thread_en,
  input  logic [N_THR-1:0]       spin_wait,
  input  logic                   fetch_valid,
  input  logic [TID_W-1:0]       fetch_tid,
  input  logic [FCW-1:0]         fetch_cnt,
  input  logic [N_THR*DCW-1:0]   drain_cnt,
  output logic                   sel_valid,
  output logic [TID_W-1:0]       sel_thread,
  output logic [N_THR*CNT_W-1:0] occupancy
);

  logic [TID_W-1:0] rr_ptr;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic hit;
    assign hit = fetch_valid && (int'(fetch_tid) == t);
    icfs_inflight_ctr #(
      .MAX_INFLIGHT(MAX_INFLIGHT),
      .CNT_W       (CNT_W),
      .FCW         (FCW),
      .DCW         (DCW)
    ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_en (hit),
      .inc_amt(fetch_cnt),
      .dec_amt(drain_cnt[t*DCW +: DCW]),
      .count  (occupancy[t*CNT_W +: CNT_W])
    );
  end

  icfs_rr_ptr #(
    .N_THR(N_THR),
    .TID_W(TID_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (fetch_valid),
    .last_tid(fetch_tid),
    .ptr     (rr_ptr)
  );

  icfs_pick #(
    .N_THR(N_THR),
    .TID_W(TID_W),
    .CNT_W(CNT_W)
  ) u_pick (
    .cnt_flat  (occupancy),
    .elig      (thread_en),
    .spin      (spin_wait),
    .ptr       (rr_ptr),
    .pick_valid(sel_valid),
    .pick_tid  (sel_thread)
  );

endmodule

// File: rtl/icfs_checker.sv
module icfs_checker #(
  parameter int N_THR        = 4,
  parameter int MAX_INFLIGHT = 20,
  parameter int TID_W        = 2,
  parameter int CNT_W        = 5,
  parameter int FCW          = 3,
  parameter int DCW          = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_THR-1:0]       thread_en,
  input logic [N_THR-1:0]       spin_wait,
  input logic                   fetch_valid,
  input logic [TID_W-1:0]       fetch_tid,
  input logic [FCW-1:0]         fetch_cnt,
  input logic [N_THR*DCW-1:0]   drain_cnt,
  input logic                   sel_valid,
  input logic [TID_W-1:0]       sel_thread,
  input logic [N_THR*CNT_W-1:0] occupancy
);

  logic [CNT_W-1:0] occ_arr [N_THR];
  logic [CNT_W-1:0] sel_occ;

  for (genvar g = 0; g < N_THR; g++) begin : g_arr
    assign occ_arr[g] = occupancy[g*CNT_W +: CNT_W];
  end
  assign sel_occ = occ_arr[sel_thread];

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> thread_en[sel_thread]);  // R8

  AST_GRANT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|thread_en) |-> sel_valid);  // R8

  AST_SPIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && spin_wait[sel_thread]) |-> ((thread_en & ~spin_wait) == '0));  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && (drain_cnt == '0)) |=> $stable(occupancy));  // R3

  for (genvar i = 0; i < N_THR; i++) begin : g_per
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ_arr[i]) <= MAX_INFLIGHT);  // R4

    AST_MIN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && thread_en[i] && (spin_wait[i] == spin_wait[sel_thread]))
        |-> (sel_occ <= occ_arr[i]));  // R6
  end

endmodule

bind icount_fetch_sel icfs_checker #(
  .N_THR       (N_THR),
  .MAX_INFLIGHT(MAX_INFLIGHT),
  .TID_W       (TID_W),
  .CNT_W       (CNT_W),
  .FCW         (FCW),
  .DCW         (DCW)
) u_icfs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .thread_en  (thread_en),
  .spin_wait  (spin_wait),
  .fetch_valid(fetch_valid),
  .fetch_tid  (fetch_tid),
  .fetch_cnt  (fetch_cnt),
  .drain_cnt  (drain_cnt),
  .sel_valid  (sel_valid),
  .sel_thread (sel_thread),
  .occupancy  (occupancy)
);

// File: tb/icount_fetch_sel_tb_top.sv
module icount_fetch_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int MAXI = 20;
  localparam int TW  = 2;
  localparam int CW  = 5;
  localparam int FW  = 3;
  localparam int DW  = 3;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    thread_en;
  logic [N-1:0]    spin_wait;
  logic            fetch_valid;
  logic [TW-1:0]   fetch_tid;
  logic [FW-1:0]   fetch_cnt;
  logic [N*DW-1:0] drain_cnt;
  logic            sel_valid;
  logic [TW-1:0]   sel_thread;
  logic [N*CW-1:0] occupancy;

  int m_cnt [N];
  int m_ptr;
  int total;
  int bad;
  bit done;

  icount_fetch_sel dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .thread_en  (thread_en),
    .spin_wait  (spin_wait),
    .fetch_valid(fetch_valid),
    .fetch_tid  (fetch_tid),
    .fetch_cnt  (fetch_cnt),
    .drain_cnt  (drain_cnt),
    .sel_valid  (sel_valid),
    .sel_thread (sel_thread),
    .occupancy  (occupancy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: expected grant from model counters, pointer and current masks.
  task automatic expect_sel(output int v, output int t);
    int calm_any;
    int best;
    calm_any = 0;
    for (int i = 0; i < N; i++) if (thread_en[i] && !spin_wait[i]) calm_any = 1;
    v = 0; t = 0; best = 0;
    for (int k = 0; k < N; k++) begin
      int j;
      bit in_tier;
      j = (m_ptr + k) % N;
      in_tier = thread_en[j] && (calm_any ? !spin_wait[j] : 1'b1);
      if (in_tier && (v == 0 || m_cnt[j] < best)) begin
        v = 1; t = j; best = m_cnt[j];
      end
    end
  endtask

  task automatic compare_all();
    int ev, et;
    string tag;
    expect_sel(ev, et);
    if (thread_en == '0) tag = "R8";
    else if ((thread_en & ~spin_wait) == '0) tag = "R7 R10";
    else tag = "R6 R9 R10";
    check({tag, " valid"}, int'(sel_valid), ev);
    check({tag, " thread"}, int'(sel_thread), et);
    for (int i = 0; i < N; i++)
      check("R2 R3 R4 R5 count", int'(occupancy[i*CW +: CW]), m_cnt[i]);
  endtask

  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      int s;
      s = m_cnt[i] + ((fetch_valid && int'(fetch_tid) == i) ? int'(fetch_cnt) : 0)
          - int'(drain_cnt[i*DW +: DW]);
      if (s < 0) s = 0;
      if (s > MAXI) s = MAXI;
      m_cnt[i] = s;
    end
    if (fetch_valid) m_ptr = (int'(fetch_tid) + 1) % N;
  endtask

  // Inputs are set by the caller just after a rising edge.
  task automatic cycle();
    #(CLK_PERIOD/2 - 1);
    compare_all();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic idle_in();
    fetch_valid = 1'b0; fetch_tid = '0; fetch_cnt = '0; drain_cnt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    m_ptr = 0;
    rst_n = 1'b0;
    thread_en = '1; spin_wait = '0;
    idle_in();
    repeat (3) @(posedge clk);
    #1;
    #(CLK_PERIOD/2 - 1);
    // R1: reset state
    check("R1 valid", int'(sel_valid), 1);
    check("R1 thread", int'(sel_thread), 0);
    check("R1 occupancy", int'(occupancy), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9: zero-size fetches move the pointer over equal counts
    for (int k = 0; k < 5; k++) begin
      fetch_valid = 1'b1; fetch_tid = TW'(k % N); fetch_cnt = '0;
      cycle();
      idle_in();
      cycle();
    end

    // R2 / R6: fill thread 2 and check it loses to the others
    fetch_valid = 1'b1; fetch_tid = 2'd2; fetch_cnt = 3'd3;
    cycle();
    idle_in();
    cycle();
    check("R2 thread2 count", int'(occupancy[2*CW +: CW]), 3);

    // R4: saturation by repeated fetches, no drain
    for (int k = 0; k < 12; k++) begin
      fetch_valid = 1'b1; fetch_tid = 2'd1; fetch_cnt = 3'd4;
      cycle();
    end
    idle_in();
    cycle();
    check("R4 ceiling", int'(occupancy[1*CW +: CW]), MAXI);

    // R3: simultaneous fetch and drain on the same thread
    fetch_valid = 1'b1; fetch_tid = 2'd1; fetch_cnt = 3'd2;
    drain_cnt = '0; drain_cnt[1*DW +: DW] = 3'd4;
    cycle();
    idle_in();
    cycle();
    check("R3 net change", int'(occupancy[1*CW +: CW]), MAXI - 2);

    // R5: over-drain clamps at zero
    drain_cnt = '1;
    for (int k = 0; k < 8; k++) cycle();
    idle_in();
    cycle();
    check("R5 floor", int'(occupancy), 0);

    // R7 / R8: spin and mask corner cases
    thread_en = 4'b0000; cycle();
    thread_en = 4'b0110; spin_wait = 4'b0110; cycle();
    spin_wait = 4'b0100; cycle();
    thread_en = 4'b1000; spin_wait = 4'b1111; cycle();
    thread_en = '1; spin_wait = '0; cycle();

    // Random mix with the fetch unit mostly following the grant
    for (int k = 0; k < 3000; k++) begin
      int ev, et;
      thread_en = N'($urandom);
      if ($urandom_range(0, 9) == 0) thread_en = '0;
      spin_wait = N'($urandom) & N'($urandom);
      expect_sel(ev, et);
      fetch_valid = (ev != 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
      fetch_tid = (ev != 0 && $urandom_range(0, 5) != 0) ? TW'(et) : TW'($urandom);
      fetch_cnt = FW'($urandom_range(0, 4));
      for (int i = 0; i < N; i++)
        drain_cnt[i*DW +: DW] = ($urandom_range(0, 2) == 0) ? DW'($urandom_range(0, 4)) : '0;
      cycle();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule